// File: doc/BRIEF.md
# Auto-masking priority interrupt controller

This block gathers a small set of level-sensitive interrupt lines and presents one interrupt request to a processor. Each line can be forced high by a software trigger bit, which is ORed with the hardware input, and can be blocked by its own mask bit. A line counts as pending while its combined level is high and its mask bit is clear. The request output goes high whenever anything is pending.

The processor services interrupts by reading a single event register. That read returns the lowest-numbered pending source together with a type field and a valid flag. The same read also acknowledges the source: its mask bit is set automatically, so the line stops requesting until software clears the mask again. If the line is still high when software clears the mask, the line becomes pending again at once.

All register accesses go over a simple synchronous bus with a one-cycle read latency. Mask and software-trigger bits are changed through separate write-one-to-set and write-one-to-clear registers, so one bit can be changed without a read-modify-write.

Top module: `autoack_intc`

## Requirements
- R1: After reset every mask bit is 1, every software trigger bit is 0, `irqOut` is 0 and `busRdata` is 0.
- R2: Source i is pending while (hwLines[i] OR trigger bit i) is 1 and mask bit i is 0. `irqOut` is registered: it equals the OR of all pending sources one clock earlier.
- R3: A write to address 3 sets, and a write to address 4 clears, each software trigger bit whose `busWdata` bit is 1. A read of address 3 or 4 returns the trigger bits in the low bits of `busRdata`.
- R4: A write to address 1 sets, and a write to address 2 clears, each mask bit whose `busWdata` bit is 1. A read of address 1 or 2 returns the mask bits in the low bits of `busRdata`.
- R5: A read of address 0 (the event register) while a source is pending returns, on the cycle after the read strobe, bit 31 = 1, bits 17:16 = 0 (type: hardware interrupt) and bits 15:0 = the source number, with every other bit 0.
- R6: When several sources are pending, the event read reports the lowest-numbered one.
- R7: The event read that reports source i sets mask bit i, so i is no longer pending afterwards.
- R8: An event read while nothing is pending returns 0 and changes no mask bit.
- R9: After an auto-mask, clearing the mask bit of a line that is still high makes it pending again in the next cycle, and `irqOut` rises one clock after that.
- R10: `busWdata` bits that are 0 in a set or clear write leave the matching mask or trigger bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hwLines | input | NUM_SRC | Level-sensitive hardware interrupt lines, synchronous to clk |
| busWe | input | 1 | Write strobe (takes precedence over busRe) |
| busRe | input | 1 | Read strobe |
| busAddr | input | 3 | Register address: 0 event, 1 mask set, 2 mask clear, 3 trigger set, 4 trigger clear |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRe |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with six sources, so every one of the 64 line patterns can be applied in full, once through the hardware inputs and once through the software triggers. For each pattern it drains the event register and predicts the order of reported numbers by finding the lowest set bit, then checks that the final read is empty and that the mask equals the pattern. Six sources keep the whole sweep to a few thousand cycles while the priority logic, the auto-masking and the empty-read case are all covered.

// File: rtl/autoack_intc_pkg.sv
package autoack_intc_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int VALID_BIT = 31;
  localparam int TYPE_LO   = 16;
  localparam int TYPE_W    = 2;
  localparam int NUM_W     = 16;

  localparam logic [ADDR_W-1:0] ADDR_EVENT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MSET  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TSET  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TCLR  = 3'd4;

  localparam logic [TYPE_W-1:0] TYPE_HWIRQ = 2'd0;

  typedef enum logic [1:0] {
    RD_EVENT = 2'd0,
    RD_MASK  = 2'd1,
    RD_TRIG  = 2'd2,
    RD_ZERO  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   maskSet;
    logic   maskClr;
    logic   trigSet;
    logic   trigClr;
    logic   evtAck;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/autoack_intc_ctrl.sv
module autoack_intc_ctrl
  import autoack_intc_pkg::*;
(
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    if (busWe) begin
      unique case (busAddr)
        ADDR_MSET: stb.maskSet = 1'b1;
        ADDR_MCLR: stb.maskClr = 1'b1;
        ADDR_TSET: stb.trigSet = 1'b1;
        ADDR_TCLR: stb.trigClr = 1'b1;
        default:   ;
      endcase
    end else if (busRe) begin
      stb.rdEn = 1'b1;
      unique case (busAddr)
        ADDR_EVENT: begin
          stb.rdSel  = RD_EVENT;
          stb.evtAck = 1'b1;
        end
        ADDR_MSET, ADDR_MCLR: stb.rdSel = RD_MASK;
        ADDR_TSET, ADDR_TCLR: stb.rdSel = RD_TRIG;
        default:              stb.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/autoack_intc_dpath.sv
module autoack_intc_dpath
  import autoack_intc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwLines,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] pendVec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic [NUM_SRC-1:0] trigVec;
  logic [NUM_SRC-1:0] wBits;
  logic [NUM_SRC-1:0] ackBits;
  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] trigNext;
  logic [IDX_W-1:0]   winIdx;
  logic               anyPend;
  logic [DATA_W-1:0]  evtWord;

  assign wBits   = wdata[NUM_SRC-1:0];
  assign pendVec = (hwLines | trigVec) & ~maskVec;
  assign anyPend = |pendVec;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign ackBits = (stb.evtAck && anyPend) ? (ONE << winIdx) : '0;

  always_comb begin
    evtWord = '0;
    if (anyPend) begin
      evtWord[VALID_BIT]                = 1'b1;
      evtWord[TYPE_LO +: TYPE_W]        = TYPE_HWIRQ;
      evtWord[NUM_W-1:0]                = NUM_W'(winIdx);
    end
  end

  always_comb begin
    maskNext = maskVec | ackBits;
    if (stb.maskSet) maskNext = maskNext | wBits;
    if (stb.maskClr) maskNext = maskNext & ~wBits;
    trigNext = trigVec;
    if (stb.trigSet) trigNext = trigNext | wBits;
    if (stb.trigClr) trigNext = trigNext & ~wBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskVec <= '1;
      trigVec <= '0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      maskVec <= maskNext;
      trigVec <= trigNext;
      irq     <= anyPend;
      if (stb.rdEn) begin
        unique case (stb.rdSel)
          RD_EVENT: rdata <= evtWord;
          RD_MASK:  rdata <= DATA_W'(maskVec);
          RD_TRIG:  rdata <= DATA_W'(trigVec);
          default:  rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/autoack_intc.sv
module autoack_intc
  import autoack_intc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwLines,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqOut
);

  strobe_t            stb;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] pendVec;

  autoack_intc_ctrl u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  autoack_intc_dpath #(.NUM_SRC(NUM_SRC)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .hwLines (hwLines),
    .stb     (stb),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .irq     (irqOut),
    .maskVec (maskVec),
    .pendVec (pendVec)
  );

endmodule

// File: rtl/autoack_intc_chk.sv
module autoack_intc_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic               busRe,
  input logic [2:0]         busAddr,
  input logic [31:0]        busWdata,
  input logic [31:0]        busRdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] pendVec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic evtRd;
  logic mclrWr;
  assign evtRd  = busRe && !busWe && (busAddr == 3'd0);
  assign mclrWr = busWe && (busAddr == 3'd2);

  // R2
  irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|pendVec));

  // R5
  event_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRd && (|pendVec) |=> busRdata[31] && (busRdata[17:16] == 2'd0)
      && (busRdata[30:18] == '0));

  // R6
  event_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRd && (|pendVec) |=>
      ((($past(pendVec) >> busRdata[IDX_W-1:0]) & ONE) == ONE) &&
      (($past(pendVec) & ~({NUM_SRC{1'b1}} << busRdata[IDX_W-1:0])) == '0));

  // R7
  auto_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRd && (|pendVec) |=> maskVec[busRdata[IDX_W-1:0]]);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRd && !(|pendVec) |=> (busRdata == '0) && $stable(maskVec));

  // R4
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    mclrWr |=> (maskVec & $past(busWdata[NUM_SRC-1:0])) == '0);

endmodule

bind autoack_intc autoack_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busRe    (busRe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .maskVec  (maskVec),
  .pendVec  (pendVec)
);

// File: tb/autoack_intc_test.sv
`timescale 1ns/1ps
module autoack_intc_test;

  localparam int N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] hwLines = '0;
  logic         busWe = 1'b0;
  logic         busRe = 1'b0;
  logic [2:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         irqOut;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  autoack_intc #(.NUM_SRC(N)) uut (
    .clk(clk), .rstN(rstN), .hwLines(hwLines),
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic drain(input logic [N-1:0] pat, input string tag);
    logic [31:0] v;
    logic [N-1:0] rem;
    logic [31:0] expW;
    rem = pat;
    for (int k = 0; k <= N; k++) begin
      busRead(3'd0, v);
      if (rem != '0) begin
        int low;
        low = 0;
        for (int b = N - 1; b >= 0; b--) if (rem[b]) low = b;
        expW = 32'h8000_0000 | 32'(low);
        check(v == expW, {"R5 R6 event ", tag}, v, expW);
        rem[low] = 1'b0;
      end else begin
        check(v == 32'h0, {"R8 empty event ", tag}, v, 32'h0);
        break;
      end
    end
    busRead(3'd1, v);
    check(v == 32'(pat), {"R7 mask after drain ", tag}, v, 32'(pat));
    @(negedge clk);
    check(irqOut == 1'b0, {"R2 irq low after drain ", tag}, 32'(irqOut), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check(irqOut == 1'b0, "R1 irq in reset", 32'(irqOut), 32'h0);
    check(busRdata == 32'h0, "R1 rdata in reset", busRdata, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busRead(3'd1, v);
    check(v == ALL, "R1 mask reset", v, ALL);
    busRead(3'd3, v);
    check(v == 32'h0, "R1 trigger reset", v, 32'h0);
    hwLines = 6'h3F;
    @(negedge clk); @(negedge clk);
    check(irqOut == 1'b0, "R1 R2 all masked", 32'(irqOut), 32'h0);
    busRead(3'd0, v);
    check(v == 32'h0, "R8 masked lines give empty event", v, 32'h0);
    busRead(3'd2, v);
    check(v == ALL, "R8 mask unchanged", v, ALL);
    hwLines = '0;

    // hardware line sweep
    for (int p = 0; p < 64; p++) begin
      hwLines = N'(p);
      busWrite(3'd2, ALL);
      @(negedge clk);
      check(irqOut == (p != 0), "R2 irq hw pattern", 32'(irqOut), 32'(p != 0));
      drain(N'(p), "hw");
      hwLines = '0;
    end

    // software trigger sweep
    for (int p = 0; p < 64; p++) begin
      busWrite(3'd3, 32'(p));
      busRead(3'd4, v);
      check(v == 32'(p), "R3 trigger readback", v, 32'(p));
      busWrite(3'd2, ALL);
      @(negedge clk);
      check(irqOut == (p != 0), "R2 irq sw pattern", 32'(irqOut), 32'(p != 0));
      drain(N'(p), "sw");
      busWrite(3'd4, ALL);
      busRead(3'd3, v);
      check(v == 32'h0, "R3 trigger clear", v, 32'h0);
    end

    // re-pend after unmask (R9)
    busWrite(3'd1, ALL);
    hwLines = 6'b000100;
    busWrite(3'd2, 32'h4);
    @(negedge clk);
    check(irqOut == 1'b1, "R2 irq single line", 32'(irqOut), 32'h1);
    busRead(3'd0, v);
    check(v == 32'h8000_0002, "R5 single line event", v, 32'h8000_0002);
    @(negedge clk);
    check(irqOut == 1'b0, "R7 irq drops after ack", 32'(irqOut), 32'h0);
    busWrite(3'd2, 32'h4);
    check(irqOut == 1'b0, "R9 irq not yet", 32'(irqOut), 32'h0);
    @(negedge clk);
    check(irqOut == 1'b1, "R9 irq back after unmask", 32'(irqOut), 32'h1);
    busRead(3'd0, v);
    check(v == 32'h8000_0002, "R9 event again", v, 32'h8000_0002);
    hwLines = '0;

    // write-one semantics (R4, R10)
    busWrite(3'd2, ALL);
    busWrite(3'd1, 32'h05);
    busRead(3'd2, v);
    check(v == 32'h05, "R4 mask set", v, 32'h05);
    busWrite(3'd2, 32'h01);
    busRead(3'd1, v);
    check(v == 32'h04, "R4 mask clear", v, 32'h04);
    busWrite(3'd1, 32'h0);
    busWrite(3'd2, 32'h0);
    busRead(3'd1, v);
    check(v == 32'h04, "R10 zero writes keep mask", v, 32'h04);
    busWrite(3'd3, 32'h12);
    busWrite(3'd3, 32'h0);
    busWrite(3'd4, 32'h0);
    busRead(3'd3, v);
    check(v == 32'h12, "R10 zero writes keep trigger", v, 32'h12);
    busWrite(3'd4, 32'h02);
    busRead(3'd4, v);
    check(v == 32'h10, "R3 partial trigger clear", v, 32'h10);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule